// File: doc/BRIEF.md
# Synchronous Serial Receiver with Receive FIFO

This block receives bytes from a clock-synchronous serial link. An external serial clock and data line are brought into the system clock domain. Data bits are captured on each rising edge of the serial clock, least significant bit first, and every completed group of eight bits becomes one byte. Each byte is placed in a 16-entry first-in first-out buffer. Software drains the buffer through a small register window, and each read of the data register removes the oldest byte.

A ready flag rises when the number of buffered bytes reaches a selectable trigger level. The flag can raise an interrupt. Software clears the flag with a two-step handshake: it reads the flag as 1, then writes 0 to it. A DMA engine can instead pull bytes through a dedicated read strobe, and each such read clears the flag with no register write.

If a byte completes while the buffer is full, the byte is dropped and a sticky overrun flag is set. Reception then stays frozen until software clears that flag. Reception also happens only while the enable bit is set.

Top module: `ssrx_top`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0, fill_o is 0 and irq_o is 0.
- R2: Bits are captured on rising serial-clock edges, LSB first, and the eighth bit completes a byte that enters the buffer. A read of address 2 returns the oldest byte and lowers fill_o by one. A read of address 2 on an empty buffer returns 0 and leaves fill_o at 0.
- R3: While control bit 0 (receive enable) is 0, serial-clock edges leave fill_o unchanged. Clearing the bit discards a partially shifted byte, so the next byte after re-enabling is assembled from fresh bits.
- R4: Control bits 3:2 select the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. The ready flag (status bit 0) becomes 1 on the clock edge after fill_o first equals or exceeds the trigger level.
- R5: irq_o is 1 exactly when the ready flag is 1 and control bit 1 (interrupt enable) is 1.
- R6: A write of 0 to status bit 0 clears the ready flag only if a read of the status register since the flag last cleared returned bit 0 as 1. Without such a read, the write has no effect.
- R7: If fill_o is still at or above the trigger level after the ready flag clears, the flag returns to 1 on the next clock edge.
- R8: A pulse on dma_rd_i pops the oldest byte, shows that byte on rdata_o in the same cycle, and clears the ready flag.
- R9: A byte completed while fill_o is 16 is discarded. It sets the overrun flag (status bit 1), and the 16 buffered bytes are kept intact.
- R10: While the overrun flag is 1, no byte is accepted. A write to address 1 with bit 1 equal to 0 clears the flag, and reception then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | External serial clock, slow relative to clk |
| sdata_i | input | 1 | Serial data line |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register select: 0 control, 1 status, 2 data, 3 unused (reads 0) |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, or the popped byte during a DMA read |
| dma_rd_i | input | 1 | DMA read strobe: pops one byte and clears the ready flag |
| irq_o | output | 1 | Receive interrupt request |
| fill_o | output | 5 | Number of bytes held in the buffer |

## Verification
The assertions assume that the serial clock is much slower than clk. Each of its levels must last at least as many clk cycles as the synchronizer has stages plus one. The data line must be steady around each rising serial edge. The assertions also assume that a register read, a register write and a DMA read never fall in the same cycle. The stimulus holds every serial-clock level for four clk cycles and changes the data line only while the serial clock is low. It issues each bus or DMA access in its own cycle, from tasks that drive on the falling clk edge.

// File: rtl/ssrx_pkg.sv
`timescale 1ns/1ps
package ssrx_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // register window decode
    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_STAT = 2'd1,
        ADR_DATA = 2'd2,
        ADR_NONE = 2'd3
    } reg_adr_e;

    // control register: [3:2] trigger select, [1] irq enable, [0] rx enable
    typedef struct packed {
        logic [1:0] trig_sel;
        logic       irq_en;
        logic       rx_en;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    // fill threshold for each trigger selection
    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/ssrx_sync_edge.sv
`timescale 1ns/1ps
// Brings the serial clock and data into the clk domain and flags rising edges.
module ssrx_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdata_i,
    output logic rise_o,
    output logic bit_o
);

    typedef struct packed {
        logic [STAGES-1:0] ck;
        logic [STAGES-1:0] dt;
        logic              last;
        logic              rise;
        logic              bitv;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ck   = {st_q.ck[STAGES-2:0], sclk_i};
        st_d.dt   = {st_q.dt[STAGES-2:0], sdata_i};
        st_d.last = st_q.ck[STAGES-1];
        st_d.rise = st_q.ck[STAGES-1] & ~st_q.last;
        st_d.bitv = st_q.dt[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.rise;
    assign bit_o  = st_q.bitv;

endmodule

// File: rtl/ssrx_deser.sv
`timescale 1ns/1ps
// Shift register: LSB-first assembly of one byte, push strobe on the last bit.
module ssrx_deser
    import ssrx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en_i,
    input  logic  rise_i,
    input  logic  bit_i,
    output logic  push_o,
    output byte_t byte_o
);

    localparam int unsigned BIT_CW = $clog2(BYTE_W);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

    typedef struct packed {
        byte_t             sh;
        logic [BIT_CW-1:0] n;
    } des_st_t;

    des_st_t st_d, st_q;
    byte_t   frame;
    logic    push;

    always_comb begin
        st_d  = st_q;
        push  = 1'b0;
        frame = {bit_i, st_q.sh[BYTE_W-1:1]};
        if (!en_i) begin
            st_d.n = '0;
        end else if (rise_i) begin
            st_d.sh = frame;
            if (st_q.n == LAST_BIT) begin
                push   = 1'b1;
                st_d.n = '0;
            end else begin
                st_d.n = st_q.n + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push_o = push;
    assign byte_o = frame;

endmodule

// File: rtl/ssrx_fifo.sv
`timescale 1ns/1ps
// Receive buffer: push ignored when full, pop ignored when empty.
module ssrx_fifo
    import ssrx_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  byte_t                      din_i,
    input  logic                       pop_i,
    output byte_t                      head_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o,
    output logic                       full_o,
    output logic                       empty_o
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
        logic [PTR_W-1:0]             wp;
        logic [PTR_W-1:0]             rp;
        logic [CNT_W-1:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_MAX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push_i & (st_q.cnt != CNT_MAX);
        do_pop  = pop_i & (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wp] = din_i;
            st_d.wp           = step(st_q.wp);
        end
        if (do_pop) begin
            st_d.rp = step(st_q.rp);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o  = st_q.mem[st_q.rp];
    assign cnt_o   = st_q.cnt;
    assign full_o  = (st_q.cnt == CNT_MAX);
    assign empty_o = (st_q.cnt == '0);

endmodule

// File: rtl/ssrx_top.sv
`timescale 1ns/1ps
// Clock-synchronous serial receive channel with trigger-level ready flag.
module ssrx_top
    import ssrx_pkg::*;
#(
    parameter int unsigned DEPTH       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk_i,
    input  logic                       sdata_i,
    input  logic                       wr_en_i,
    input  logic                       rd_en_i,
    input  logic [1:0]                 addr_i,
    input  logic [7:0]                 wdata_i,
    output logic [7:0]                 rdata_o,
    input  logic                       dma_rd_i,
    output logic                       irq_o,
    output logic [$clog2(DEPTH+1)-1:0] fill_o
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        ctrl_t ctrl;
        logic  rdy;
        logic  arm;
        logic  ovr;
        logic  irq;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             rise, bitv;
    logic             push;
    byte_t            rx_byte;
    byte_t            head;
    logic [CNT_W-1:0] cnt;
    logic             full, empty;
    logic             pop;
    logic             wr_ctrl, wr_stat, rd_stat, rd_data;
    logic             sw_clr, hit;
    byte_t            rdata;
    logic             unused_wdata;

    assign unused_wdata = ^wdata_i[7:CTRL_W];

    ssrx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk_i),
        .sdata_i (sdata_i),
        .rise_o  (rise),
        .bit_o   (bitv)
    );

    ssrx_deser u_deser (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (st_q.ctrl.rx_en & ~st_q.ovr),
        .rise_i (rise),
        .bit_i  (bitv),
        .push_o (push),
        .byte_o (rx_byte)
    );

    ssrx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .din_i   (rx_byte),
        .pop_i   (pop),
        .head_o  (head),
        .cnt_o   (cnt),
        .full_o  (full),
        .empty_o (empty)
    );

    always_comb begin
        wr_ctrl = wr_en_i & (addr_i == ADR_CTRL);
        wr_stat = wr_en_i & (addr_i == ADR_STAT);
        rd_stat = rd_en_i & (addr_i == ADR_STAT);
        rd_data = rd_en_i & (addr_i == ADR_DATA);
        pop     = rd_data | dma_rd_i;
        hit     = (cnt >= CNT_W'(trig_level(st_q.ctrl.trig_sel)));
        sw_clr  = wr_stat & ~wdata_i[0] & st_q.arm;
    end

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);
        end
        // two-step clear: a status read that sees the flag set arms the clear
        if (rd_stat && st_q.rdy) begin
            st_d.arm = 1'b1;
        end
        if (sw_clr || dma_rd_i) begin
            st_d.arm = 1'b0;
            st_d.rdy = 1'b0;
        end else begin
            st_d.rdy = st_q.rdy | hit;
        end
        if (push && full) begin
            st_d.ovr = 1'b1;
        end else if (wr_stat && !wdata_i[1]) begin
            st_d.ovr = 1'b0;
        end
        st_d.irq = st_d.rdy & st_d.ctrl.irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (dma_rd_i) begin
            rdata = empty ? '0 : head;
        end else if (rd_en_i) begin
            case (addr_i)
                ADR_CTRL: rdata = byte_t'(st_q.ctrl);
                ADR_STAT: rdata = {6'd0, st_q.ovr, st_q.rdy};
                ADR_DATA: rdata = empty ? '0 : head;
                default:  rdata = '0;
            endcase
        end
    end

    assign rdata_o = rdata;
    assign irq_o   = st_q.irq;
    assign fill_o  = cnt;

endmodule

// File: rtl/ssrx_chk.sv
`timescale 1ns/1ps
// Property checker for ssrx_top, attached by bind below.
module ssrx_chk
    import ssrx_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [1:0]                 addr,
    input logic [7:0]                 wdata,
    input logic                       dma_rd,
    input logic [$clog2(DEPTH+1)-1:0] fill,
    input logic                       rdy,
    input logic                       ovr,
    input logic                       rx_en,
    input logic [1:0]                 trig_sel
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic stat_wr, ovr_clr_wr;
    assign stat_wr    = wr_en && (addr == 2'd1);
    assign ovr_clr_wr = stat_wr && !wdata[1];

    AST_FILL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH)); // R9

    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fill <= $past(fill) + 1'b1) && ($past(fill) <= fill + 1'b1)); // R2

    AST_RDY_ON_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && !dma_rd && fill >= CNT_W'(trig_level(trig_sel))) |=> rdy); // R4

    AST_RDY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !dma_rd && !stat_wr) |=> rdy); // R6

    AST_DMA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rd |=> !rdy); // R8

    AST_IDLE_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (fill <= $past(fill))); // R3

    AST_OVR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr_wr) |=> (ovr && fill <= $past(fill))); // R10

endmodule

bind ssrx_top ssrx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .addr     (addr_i),
    .wdata    (wdata_i),
    .dma_rd   (dma_rd_i),
    .fill     (fill_o),
    .rdy      (st_q.rdy),
    .ovr      (st_q.ovr),
    .rx_en    (st_q.ctrl.rx_en),
    .trig_sel (st_q.ctrl.trig_sel)
);

// File: tb/sim_ssrx_top.sv
`timescale 1ns/1ps
module sim_ssrx_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       sdata = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       dma_rd = 1'b0;
    logic       irq;
    logic [4:0] fill;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    logic [7:0]  mq[$];

    always #2.5 clk = ~clk;

    ssrx_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_i   (sclk),
        .sdata_i  (sdata),
        .wr_en_i  (wr_en),
        .rd_en_i  (rd_en),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .dma_rd_i (dma_rd),
        .irq_o    (irq),
        .fill_o   (fill)
    );

    function automatic logic [7:0] ctrl_val(input int trig, input bit ie, input bit en);
        return {4'd0, 2'(trig), ie, en};
    endfunction

    function automatic int trig_of(input int sel);
        case (sel)
            0:       return 1;
            1:       return 4;
            2:       return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic dma_pop(output logic [7:0] v);
        @(negedge clk);
        dma_rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        dma_rd = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            sdata = b[i];
            idle(4);
            sclk = 1'b1;
            idle(4);
            sclk = 1'b0;
        end
        idle(5);
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic drain(input string req);
        logic [7:0] v;
        while (mq.size() != 0) begin
            rd(2'd2, v);
            chk(req, int'(v), int'(mq.pop_front()));
        end
        chk(req, int'(fill), 0);
    endtask

    task automatic clear_rdy();
        logic [7:0] v;
        rd(2'd1, v);
        wr(2'd1, 8'h02);
        idle(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] b;
        void'($urandom(32'd20240611));
        idle(5);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(2'd0, v);  chk("R1 ctrl", int'(v), 0);
        rd(2'd1, v);  chk("R1 status", int'(v), 0);
        chk("R1 fill", int'(fill), 0);
        chk("R1 irq", int'(irq), 0);

        // R2 R4 R5 single byte, trigger 1
        wr(2'd0, ctrl_val(0, 1, 1));
        b = 8'($urandom);
        send_byte(b); mq.push_back(b);
        chk("R2 fill after byte", int'(fill), 1);
        chk("R5 irq with ready", int'(irq), 1);
        rd(2'd1, v);  chk("R4 ready at trigger 1", int'(v), 1);
        rd(2'd2, v);  chk("R2 data LSB first", int'(v), int'(mq.pop_front()));
        chk("R2 fill after pop", int'(fill), 0);

        // R6 armed clear
        wr(2'd1, 8'h02);
        chk("R6 cleared after read-then-write", int'(irq), 0);
        idle(2);
        chk("R6 stays clear below trigger", int'(irq), 0);

        // R6 write without read has no effect, R7 re-set
        b = 8'($urandom);
        send_byte(b); mq.push_back(b);
        chk("R5 irq raised", int'(irq), 1);
        wr(2'd1, 8'h02);
        idle(1);
        chk("R6 unarmed write ignored", int'(irq), 1);
        rd(2'd1, v);
        wr(2'd1, 8'h02);
        chk("R7 flag cleared for one cycle", int'(irq), 0);
        @(negedge clk);
        chk("R7 flag returns while fill meets trigger", int'(irq), 1);
        drain("R2 drain");
        clear_rdy();
        chk("R6 clear after drain", int'(irq), 0);

        // R2 empty read
        rd(2'd2, v);
        chk("R2 empty read value", int'(v), 0);
        chk("R2 empty read fill", int'(fill), 0);

        // R4 trigger levels 4, 8, 14 and R8 DMA path
        for (int sel = 1; sel < 4; sel++) begin
            wr(2'd0, ctrl_val(sel, 1, 1));
            for (int k = 0; k < trig_of(sel) - 1; k++) begin
                b = 8'($urandom);
                send_byte(b); mq.push_back(b);
            end
            chk("R4 below trigger", int'(irq), 0);
            b = 8'($urandom);
            send_byte(b); mq.push_back(b);
            chk("R4 at trigger", int'(irq), 1);
            rd(2'd1, v);
            chk("R4 status ready bit", int'(v), 1);
            if (sel == 3) begin
                dma_pop(v);
                chk("R8 dma data", int'(v), int'(mq.pop_front()));
                idle(2);
                chk("R8 dma clears ready", int'(irq), 0);
                chk("R8 dma pops", int'(fill), 13);
            end
            drain("R2 drain after trigger");
            clear_rdy();
        end

        // R3 receive disabled, partial frame discarded
        wr(2'd0, ctrl_val(0, 1, 0));
        send_byte(8'h3C);
        chk("R3 disabled no byte", int'(fill), 0);
        chk("R3 disabled no irq", int'(irq), 0);
        wr(2'd0, ctrl_val(0, 1, 1));
        send_bits(8'h0D, 4);
        wr(2'd0, ctrl_val(0, 1, 0));
        wr(2'd0, ctrl_val(0, 1, 1));
        b = 8'hA6;
        send_byte(b); mq.push_back(b);
        chk("R3 fresh frame count", int'(fill), 1);
        drain("R3 fresh frame data");
        clear_rdy();

        // R9 R10 overrun
        wr(2'd0, ctrl_val(0, 0, 1));
        for (int k = 0; k < 16; k++) begin
            b = 8'($urandom);
            send_byte(b); mq.push_back(b);
        end
        chk("R9 full", int'(fill), 16);
        rd(2'd1, v);  chk("R9 no overrun yet", int'(v), 1);
        send_byte(8'h5A);
        rd(2'd1, v);  chk("R9 overrun flag", int'(v), 3);
        chk("R9 frame dropped", int'(fill), 16);
        send_byte(8'hC3);
        chk("R10 frozen while full", int'(fill), 16);
        rd(2'd2, v);  chk("R9 contents kept", int'(v), int'(mq.pop_front()));
        send_byte(8'h77);
        chk("R10 frozen with room", int'(fill), 15);
        drain("R9 contents kept");
        wr(2'd1, 8'h01);
        rd(2'd1, v);  chk("R10 overrun cleared", int'(v[1]), 0);
        b = 8'($urandom);
        send_byte(b); mq.push_back(b);
        chk("R10 reception resumes", int'(fill), 1);
        drain("R10 data after resume");
        clear_rdy();

        // random mix of arrivals, register pops and DMA pops
        wr(2'd0, ctrl_val(0, 1, 1));
        for (int k = 0; k < 24; k++) begin
            b = 8'($urandom);
            send_byte(b); mq.push_back(b);
            case ($urandom % 4)
                0: begin
                    rd(2'd2, v);
                    chk("R2 random pop", int'(v), int'(mq.pop_front()));
                end
                1: begin
                    dma_pop(v);
                    chk("R8 random dma pop", int'(v), int'(mq.pop_front()));
                end
                default: ;
            endcase
            idle(1);
            chk("R2 random fill", int'(fill), mq.size());
        end
        drain("R2 random drain");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule